// File: doc/BRIEF.md
# Reloading Tick Timer

This block is a down-counting timer meant to give an operating system its periodic tick. Software programs a reload value and sets the run bit. The counter then steps down once on every cycle in which both the run bit and the external clock enable `tick_en` are high. After it reaches zero it takes the reload value on the next counted cycle, so the tick period is the reload value plus one counted cycles.

Each arrival at zero sets a sticky event flag. Reading the control/status register clears that flag. When the interrupt-enable bit is set, the same arrival also raises a one-cycle pulse on `tick_irq`. Any write to the current-value register clears the counter, whatever the data. A reload value of zero parks the counter at zero while the run bit stays set. The register port is a plain address / write-strobe / read-strobe interface with combinational read data.

Top module: `stick_timer`

## Requirements
- R1: After reset the control/status register, the reload register and the current value all read 0, and `tick_irq` is low.
- R2: On a clock edge where the run bit (address 0x0, bit 0) and `tick_en` are both high and the current value is not 0, the current value drops by one.
- R3: On a counted edge where the current value is 0, the current value loads the reload value (address 0x4), using all 24 bits.
- R4: The event flag (address 0x0, bit 16) sets when a counted edge moves the current value from 1 to 0. A read strobe on address 0x0 returns the flag's value before the clear, and the flag is 0 after that edge.
- R5: A write to address 0x8 clears the current value to 0 whatever the data, takes priority over counting, and does not set the event flag.
- R6: When the run bit is 0 or `tick_en` is low, the current value does not change.
- R7: With a reload value of 0, the counter stays at 0 while running, and neither the event flag nor `tick_irq` is raised.
- R8: `tick_irq` is high for exactly one cycle, in the cycle the current value first reads 0, and only if the interrupt-enable bit (address 0x0, bit 1) is set. It never pulses when that bit is clear.
- R9: A read strobe on address 0x0 on the same edge as a 1-to-0 move leaves the event flag set.
- R10: Register bits above bit 23 of the reload and current-value registers read as 0. The control/status register returns only bits 0, 1 and 16, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count qualifier; the counter moves only on cycles where it is high |
| addr | input | 4 | Register byte address (0x0 control/status, 0x4 reload, 0x8 current) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; on address 0x0 it clears the event flag |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_irq | output | 1 | One-cycle pulse when the counter reaches zero |

## Verification
The bench uses the default parameters: a 24-bit counter behind a 32-bit data port with 4-bit addresses. This puts the padding of bits 24 to 31 in reach, as well as a full-scale reload of 0xFFFFFF and its first decrement. The short reload values 2, 3 and 5 give whole wrap periods, back-to-back pulses and the collision of a status read with a move to zero, all within a few dozen cycles. A zero reload covers the parking case.

// File: rtl/stick_pkg.sv
package stick_pkg;
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_RELOAD = 4;
  localparam int unsigned OFS_CURR   = 8;

  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_IE     = 1;
  localparam int unsigned BIT_FLAG   = 16;

  typedef struct packed {
    logic run;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/stick_rst_sync.sv
module stick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/stick_regs.sv
module stick_regs
  import stick_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_val,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload_val,
  output logic              cur_clr,
  output logic              flag_rd,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic sel_ctrl, sel_reload, sel_curr;
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] reload_rd, curr_rd, ctrl_rd;

  assign sel_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign sel_reload = (addr == ADDR_W'(OFS_RELOAD));
  assign sel_curr   = (addr == ADDR_W'(OFS_CURR));

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (wr_en && sel_ctrl) begin
      ctrl_d.run    = wdata[BIT_RUN];
      ctrl_d.irq_en = wdata[BIT_IE];
    end
    if (wr_en && sel_reload) reload_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign reload_rd = {{PAD_W{1'b0}}, reload_q};
      assign curr_rd   = {{PAD_W{1'b0}}, cur_val};
    end else begin : g_nopad
      assign reload_rd = reload_q[DATA_W-1:0];
      assign curr_rd   = cur_val[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[BIT_RUN]  = ctrl_q.run;
    ctrl_rd[BIT_IE]   = ctrl_q.irq_en;
    ctrl_rd[BIT_FLAG] = flag;
  end

  always_comb begin
    if (sel_ctrl)        rdata = ctrl_rd;
    else if (sel_reload) rdata = reload_rd;
    else if (sel_curr)   rdata = curr_rd;
    else                 rdata = '0;
  end

  assign ctrl       = ctrl_q;
  assign reload_val = reload_q;
  assign cur_clr    = wr_en && sel_curr;
  assign flag_rd    = rd_en && sel_ctrl;
endmodule

// File: rtl/stick_core.sv
module stick_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_ce,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur_val,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_ce) begin
      if (at_zero) begin
        cnt_d = reload_val;
      end else begin
        cnt_d = cnt_q - ONE;
        hit   = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cur_val = cnt_q;
endmodule

// File: rtl/stick_flag.sv
module stick_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rd_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (hit)         flag_d = 1'b1;
    else if (rd_clr) flag_d = 1'b0;
    irq_d = hit && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/stick_timer.sv
module stick_timer
  import stick_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_irq
);
  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic             run_w, ie_w;
  logic [CNT_W-1:0] reload_val, cur_val;
  logic             cur_clr, flag_rd, hit, flag;
  logic             cnt_ce;

  stick_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .cur_val    (cur_val),
    .flag       (flag),
    .ctrl       (ctrl),
    .reload_val (reload_val),
    .cur_clr    (cur_clr),
    .flag_rd    (flag_rd),
    .rdata      (rdata)
  );

  assign run_w  = ctrl.run;
  assign ie_w   = ctrl.irq_en;
  assign cnt_ce = run_w && tick_en;

  stick_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_ce     (cnt_ce),
    .clr        (cur_clr),
    .reload_val (reload_val),
    .cur_val    (cur_val),
    .hit        (hit)
  );

  stick_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hit    (hit),
    .rd_clr (flag_rd),
    .irq_en (ie_w),
    .flag   (flag),
    .irq    (tick_irq)
  );
endmodule

// File: rtl/stick_timer_chk.sv
module stick_timer_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              run,
  input logic [CNT_W-1:0]  reload_val,
  input logic [CNT_W-1:0]  cur_val,
  input logic              flag,
  input logic              tick_irq
);
  logic cur_wr, ctrl_rd, go, at_one;
  assign cur_wr  = wr_en && (addr == ADDR_W'(8));
  assign ctrl_rd = rd_en && (addr == ADDR_W'(0));
  assign go      = run && tick_en && !cur_wr;
  assign at_one  = (cur_val == CNT_W'(1));

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cur_val != '0) |=> (cur_val == CNT_W'($past(cur_val) - CNT_W'(1))));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cur_val == '0) |=> (cur_val == $past(reload_val)));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && at_one) |=> flag);

  p_wr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (cur_val == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick_en) && !cur_wr) |=> $stable(cur_val));

  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cur_val == '0 && reload_val == '0) |=> (cur_val == '0 && !tick_irq));

  p_irq_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (cur_val == '0 && flag));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);

  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && at_one && ctrl_rd) |=> flag);
endmodule

bind stick_timer stick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick_en    (tick_en),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .run        (run_w),
  .reload_val (reload_val),
  .cur_val    (cur_val),
  .flag       (flag),
  .tick_irq   (tick_irq)
);

// File: tb/sim_stick_timer.sv
module sim_stick_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_CURR = 4'h8;

  logic        clk, rst_n, tick_en, wr_en, rd_en, tick_irq;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  int n_chk, n_bad;
  bit done;

  stick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .tick_irq(tick_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(A_CTRL, v);   check("R1 ctrl", v, 32'h0);
    peek(A_RELOAD, v); check("R1 reload", v, 32'h0);
    peek(A_CURR, v);   check("R1 current", v, 32'h0);
    check("R1 irq", {31'b0, tick_irq}, 32'h0);
  endtask

  task automatic t_period();
    logic [31:0] v;
    tick_en = 1'b1;
    reg_wr(A_RELOAD, 32'd5);
    reg_wr(A_CURR, 32'h55);
    reg_wr(A_CTRL, 32'h3);
    for (int i = 1; i <= 12; i++) begin
      int ph;
      ph = (i - 1) % 6;
      @(negedge clk);
      peek(A_CURR, v);
      check((ph == 0) ? "R3 reload value" : "R2 decrement", v, 32'(5 - ph));
      check("R8 irq pulse", {31'b0, tick_irq}, {31'b0, ph == 5});
    end
    tick_en = 1'b0;
    reg_rd(A_CTRL, v); check("R4 flag read", v, 32'h0001_0003);
    reg_rd(A_CTRL, v); check("R4 flag cleared", v, 32'h0000_0003);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    reg_wr(A_CTRL, 32'h1);
    reg_wr(A_RELOAD, 32'd7);
    reg_wr(A_CURR, 32'h0);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    peek(A_CURR, v); check("R2 after three", v, 32'd5);
    repeat (4) @(negedge clk);
    peek(A_CURR, v); check("R6 tick_en low", v, 32'd5);
    reg_wr(A_CTRL, 32'h0);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    peek(A_CURR, v); check("R6 run low", v, 32'd5);
  endtask

  task automatic t_wr_clear();
    logic [31:0] v;
    reg_rd(A_CTRL, v);
    reg_wr(A_CURR, 32'h00AB_CDEF);
    peek(A_CURR, v); check("R5 cleared", v, 32'h0);
    reg_rd(A_CTRL, v); check("R5 no flag", v & 32'h0001_0000, 32'h0);
  endtask

  task automatic t_park();
    logic [31:0] v;
    logic seen;
    reg_wr(A_CTRL, 32'h3);
    reg_wr(A_RELOAD, 32'h0);
    reg_wr(A_CURR, 32'h0);
    reg_rd(A_CTRL, v);
    seen = 1'b0;
    tick_en = 1'b1;
    repeat (10) begin
      @(negedge clk);
      seen |= tick_irq;
    end
    tick_en = 1'b0;
    check("R7 no irq", {31'b0, seen}, 32'h0);
    peek(A_CURR, v); check("R7 parked", v, 32'h0);
    reg_rd(A_CTRL, v); check("R7 no flag", v, 32'h0000_0003);
  endtask

  task automatic t_no_ie();
    logic [31:0] v;
    logic seen;
    reg_wr(A_CTRL, 32'h1);
    reg_wr(A_RELOAD, 32'd2);
    reg_wr(A_CURR, 32'h0);
    reg_rd(A_CTRL, v);
    seen = 1'b0;
    tick_en = 1'b1;
    repeat (8) begin
      @(negedge clk);
      seen |= tick_irq;
    end
    tick_en = 1'b0;
    check("R8 masked irq", {31'b0, seen}, 32'h0);
    reg_rd(A_CTRL, v); check("R4 flag without ie", v, 32'h0001_0001);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    reg_wr(A_CTRL, 32'h3);
    reg_wr(A_RELOAD, 32'd3);
    reg_wr(A_CURR, 32'h0);
    reg_rd(A_CTRL, v);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    addr = A_CTRL; rd_en = 1'b1;
    #1 check("R9 read before hit", v & 32'h0001_0000, 32'h0);
    v = rdata; check("R9 read returns old flag", v & 32'h0001_0000, 32'h0);
    @(negedge clk);
    rd_en = 1'b0; tick_en = 1'b0;
    check("R8 irq at collision", {31'b0, tick_irq}, 32'h1);
    reg_rd(A_CTRL, v); check("R9 flag kept", v, 32'h0001_0003);
    reg_rd(A_CTRL, v); check("R4 cleared after", v, 32'h0000_0003);
  endtask

  task automatic t_map();
    logic [31:0] v;
    reg_wr(A_RELOAD, 32'hFFFF_FFFF);
    peek(A_RELOAD, v); check("R10 reload width", v, 32'h00FF_FFFF);
    reg_wr(A_CTRL, 32'hFFFF_FFFF);
    peek(A_CTRL, v); check("R10 ctrl bits", v, 32'h0000_0003);
    peek(4'hC, v); check("R10 unmapped", v, 32'h0);
    reg_wr(A_CURR, 32'h0);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    peek(A_CURR, v); check("R3 full reload", v, 32'h00FF_FFFF);
    tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    peek(A_CURR, v); check("R2 full decrement", v, 32'h00FF_FFFE);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_period();
    t_hold();
    t_wr_clear();
    t_park();
    t_no_ie();
    t_collide();
    t_map();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule